// File: doc/BRIEF.md
# Accumulator ALU with Condition Codes

This block is an arithmetic and logic unit built around a single accumulator register. The accumulator is always the first operand. The second operand arrives on a parallel input that stands in for the temporary operand register, and every result goes back into the accumulator. A condition-code register records carry, zero, overflow, sign, even parity and half carry for the most recent operation. It also holds an interrupt-enable bit, which has its own set and clear inputs.

An operation is requested by placing an operation code and an operand on the inputs and raising the execute strobe for one clock. A single binary adder serves all arithmetic. Subtraction feeds it the bitwise inverse of the operand together with a carry-in of one. Increment and decrement reuse the same adder with constant operands. The carry flag can be fed back into the adder, so that wide sums can be built a word at a time.

Top module: `accAlu`

## Requirements
- R1: A synchronous, active-high `rst` clears the accumulator and all seven flag bits on the next rising edge. The zero flag is included and also reads 0.
- R2: While `exec` is low, the accumulator and flag bits 0 to 5 hold their values. With `exec` high, operation codes 9 to 15 also leave them unchanged.
- R3: Code 0 adds the operand to the accumulator. Code 1 adds the operand plus the carry flag. Code 2 subtracts by adding the inverted operand plus one. All three write the carry out of the most significant bit into flag bit 0; after a subtraction a 1 there means no borrow.
- R4: Code 3 (AND with operand), code 4 (OR with operand), code 5 (invert accumulator) and code 6 (load zero) clear carry (bit 0), overflow (bit 2) and half carry (bit 5).
- R5: Code 7 adds one and code 8 subtracts one, both modulo 2^WIDTH. Both leave the carry flag unchanged. Overflow and half carry come from adding 0 with carry-in 1 (code 7), or all ones with carry-in 0 (code 8).
- R6: After any operation with code 0 to 8, flag bit 1 is 1 exactly when the new accumulator is zero.
- R7: After codes 0, 1, 2, 7 and 8, flag bit 2 is 1 exactly when the adder's two inputs have equal sign bits and the result's sign bit differs from them.
- R8: After any operation with code 0 to 8, flag bit 3 equals the most significant bit of the new accumulator.
- R9: After any operation with code 0 to 8, flag bit 4 is 1 when the new accumulator holds an even number of one bits, and 0 otherwise.
- R10: After codes 0, 1, 2, 7 and 8, flag bit 5 is the carry out of bit WIDTH/2-1 into bit WIDTH/2.
- R11: Flag bit 6 (interrupt enable) clears when `intEnClr` is high and sets when only `intEnSet` is high, so clear wins over set. It does not depend on `exec` and no ALU operation changes it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| opCode | input | 4 | Operation selector |
| operand | input | WIDTH | Second ALU operand |
| exec | input | 1 | Execute strobe; the operation takes effect on this edge |
| intEnSet | input | 1 | Set the interrupt-enable flag |
| intEnClr | input | 1 | Clear the interrupt-enable flag (has priority) |
| acc | output | WIDTH | Accumulator contents |
| flags | output | 7 | {intEn, halfCarry, parity, sign, overflow, zero, carry} |

## Verification
The bench builds the block with WIDTH = 4, so the half carry comes out of bit 1 and each word has only sixteen values. At that width every accumulator and operand pair can be run through all sixteen operation codes. Add with carry, increment and decrement are repeated with the carry flag preloaded to one. Every flag is therefore seen at every boundary: the signed overflow wrap, the nibble carry, borrow on subtraction and parity of each value.

// File: rtl/accAluPkg.sv
package accAluPkg;

  localparam int FLAG_BITS = 7;
  localparam int F_CARRY   = 0;
  localparam int F_ZERO    = 1;
  localparam int F_OVF     = 2;
  localparam int F_SIGN    = 3;
  localparam int F_PARITY  = 4;
  localparam int F_HALF    = 5;
  localparam int F_INTEN   = 6;

  typedef enum logic [3:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_AND = 4'd3,
    OP_OR  = 4'd4,
    OP_CPL = 4'd5,
    OP_CLR = 4'd6,
    OP_INC = 4'd7,
    OP_DEC = 4'd8
  } opCode_e;

  // second adder input source
  typedef enum logic [1:0] {
    B_OPND = 2'd0,
    B_INV  = 2'd1,
    B_ZERO = 2'd2,
    B_ONES = 2'd3
  } bSel_e;

  typedef enum logic [1:0] {
    CIN_ZERO  = 2'd0,
    CIN_ONE   = 2'd1,
    CIN_CARRY = 2'd2
  } cinSel_e;

  typedef enum logic [1:0] {
    L_AND = 2'd0,
    L_OR  = 2'd1,
    L_CPL = 2'd2,
    L_CLR = 2'd3
  } logicSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic      writeBack;
    logic      useAdder;
    bSel_e     bSel;
    cinSel_e   cinSel;
    logic      keepCarry;
    logicSel_e logicSel;
  } aluCtrl_t;

endpackage

// File: rtl/accAluCtrl.sv
module accAluCtrl
  import accAluPkg::*;
(
  input  logic [3:0] opCode,
  input  logic       exec,
  output aluCtrl_t   ctrl
);

  always_comb begin
    ctrl           = '0;
    ctrl.bSel      = B_OPND;
    ctrl.cinSel    = CIN_ZERO;
    ctrl.logicSel  = L_CLR;
    ctrl.writeBack = 1'b0;
    case (opCode)
      OP_ADD: begin
        ctrl.writeBack = exec;
        ctrl.useAdder  = 1'b1;
      end
      OP_ADC: begin
        ctrl.writeBack = exec;
        ctrl.useAdder  = 1'b1;
        ctrl.cinSel    = CIN_CARRY;
      end
      OP_SUB: begin
        ctrl.writeBack = exec;
        ctrl.useAdder  = 1'b1;
        ctrl.bSel      = B_INV;
        ctrl.cinSel    = CIN_ONE;
      end
      OP_AND: begin
        ctrl.writeBack = exec;
        ctrl.logicSel  = L_AND;
      end
      OP_OR: begin
        ctrl.writeBack = exec;
        ctrl.logicSel  = L_OR;
      end
      OP_CPL: begin
        ctrl.writeBack = exec;
        ctrl.logicSel  = L_CPL;
      end
      OP_CLR: begin
        ctrl.writeBack = exec;
        ctrl.logicSel  = L_CLR;
      end
      OP_INC: begin
        ctrl.writeBack = exec;
        ctrl.useAdder  = 1'b1;
        ctrl.bSel      = B_ZERO;
        ctrl.cinSel    = CIN_ONE;
        ctrl.keepCarry = 1'b1;
      end
      OP_DEC: begin
        ctrl.writeBack = exec;
        ctrl.useAdder  = 1'b1;
        ctrl.bSel      = B_ONES;
        ctrl.keepCarry = 1'b1;
      end
      default: ctrl.writeBack = 1'b0;
    endcase
  end

endmodule

// File: rtl/accAluDatapath.sv
module accAluDatapath
  import accAluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  aluCtrl_t             ctrl,
  input  logic [WIDTH-1:0]     operand,
  input  logic                 intEnSet,
  input  logic                 intEnClr,
  output logic [WIDTH-1:0]     acc,
  output logic [FLAG_BITS-1:0] flags
);

  localparam int HALF = WIDTH / 2;
  localparam int MSB  = WIDTH - 1;

  logic [WIDTH-1:0]     accQ;
  logic [FLAG_BITS-1:0] flagQ;
  logic [WIDTH-1:0]     bVal;
  logic                 cinBit;
  logic [WIDTH:0]       sum;
  logic [HALF:0]        halfSum;
  logic [WIDTH-1:0]     logicRes;
  logic [WIDTH-1:0]     result;
  logic                 carryNext;
  logic                 ovfNext;
  logic                 halfNext;

  always_comb begin
    case (ctrl.bSel)
      B_OPND:  bVal = operand;
      B_INV:   bVal = ~operand;
      B_ZERO:  bVal = '0;
      default: bVal = '1;
    endcase
    case (ctrl.cinSel)
      CIN_ONE:   cinBit = 1'b1;
      CIN_CARRY: cinBit = flagQ[F_CARRY];
      default:   cinBit = 1'b0;
    endcase
  end

  // one shared adder for every arithmetic operation
  assign sum     = {1'b0, accQ} + {1'b0, bVal} + {{WIDTH{1'b0}}, cinBit};
  assign halfSum = {1'b0, accQ[HALF-1:0]} + {1'b0, bVal[HALF-1:0]} + {{HALF{1'b0}}, cinBit};

  always_comb begin
    case (ctrl.logicSel)
      L_AND:   logicRes = accQ & operand;
      L_OR:    logicRes = accQ | operand;
      L_CPL:   logicRes = ~accQ;
      default: logicRes = '0;
    endcase
  end

  always_comb begin
    if (ctrl.useAdder) begin
      result    = sum[WIDTH-1:0];
      carryNext = ctrl.keepCarry ? flagQ[F_CARRY] : sum[WIDTH];
      ovfNext   = (accQ[MSB] == bVal[MSB]) && (sum[MSB] != accQ[MSB]);
      halfNext  = halfSum[HALF];
    end else begin
      result    = logicRes;
      carryNext = 1'b0;
      ovfNext   = 1'b0;
      halfNext  = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      accQ  <= '0;
      flagQ <= '0;
    end else begin
      if (ctrl.writeBack) begin
        accQ            <= result;
        flagQ[F_CARRY]  <= carryNext;
        flagQ[F_ZERO]   <= (result == '0);
        flagQ[F_OVF]    <= ovfNext;
        flagQ[F_SIGN]   <= result[MSB];
        flagQ[F_PARITY] <= ~(^result);
        flagQ[F_HALF]   <= halfNext;
      end
      if (intEnClr)      flagQ[F_INTEN] <= 1'b0;
      else if (intEnSet) flagQ[F_INTEN] <= 1'b1;
    end
  end

  assign acc   = accQ;
  assign flags = flagQ;

endmodule

// File: rtl/accAlu.sv
module accAlu
  import accAluPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [3:0]           opCode,
  input  logic [WIDTH-1:0]     operand,
  input  logic                 exec,
  input  logic                 intEnSet,
  input  logic                 intEnClr,
  output logic [WIDTH-1:0]     acc,
  output logic [FLAG_BITS-1:0] flags
);

  aluCtrl_t ctrl;

  accAluCtrl u_ctrl (
    .opCode (opCode),
    .exec   (exec),
    .ctrl   (ctrl)
  );

  accAluDatapath #(.WIDTH(WIDTH)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctrl     (ctrl),
    .operand  (operand),
    .intEnSet (intEnSet),
    .intEnClr (intEnClr),
    .acc      (acc),
    .flags    (flags)
  );

endmodule

// File: rtl/accAluChecker.sv
module accAluChecker #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rst,
  input logic [3:0]       opCode,
  input logic [WIDTH-1:0] operand,
  input logic             exec,
  input logic             intEnSet,
  input logic             intEnClr,
  input logic [WIDTH-1:0] acc,
  input logic [6:0]       flags
);

  logic validExec;
  assign validExec = exec && (opCode <= 4'd8);

  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (acc == '0) && (flags == '0));

  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !exec |=> $stable(acc) && (flags[5:0] == $past(flags[5:0])));

  assert_bad_code_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (exec && opCode > 4'd8) |=> $stable(acc) && (flags[5:0] == $past(flags[5:0])));

  assert_logic_clears_R4: assert property (@(posedge clk) disable iff (rst)
    (exec && opCode >= 4'd3 && opCode <= 4'd6) |=> !flags[0] && !flags[2] && !flags[5]);

  assert_step_keeps_carry_R5: assert property (@(posedge clk) disable iff (rst)
    (exec && (opCode == 4'd7 || opCode == 4'd8)) |=> flags[0] == $past(flags[0]));

  assert_inc_value_R5: assert property (@(posedge clk) disable iff (rst)
    (exec && opCode == 4'd7) |=> acc == WIDTH'($past(acc) + 1'b1));

  assert_zero_flag_R6: assert property (@(posedge clk) disable iff (rst)
    validExec |=> flags[1] == (acc == '0));

  assert_sign_flag_R8: assert property (@(posedge clk) disable iff (rst)
    validExec |=> flags[3] == acc[WIDTH-1]);

  assert_parity_flag_R9: assert property (@(posedge clk) disable iff (rst)
    validExec |=> flags[4] == ($countones(acc) % 2 == 0));

  assert_inten_clear_R11: assert property (@(posedge clk) disable iff (rst)
    intEnClr |=> !flags[6]);

  assert_inten_set_R11: assert property (@(posedge clk) disable iff (rst)
    (intEnSet && !intEnClr) |=> flags[6]);

  assert_inten_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (!intEnSet && !intEnClr) |=> $stable(flags[6]));

endmodule

bind accAlu accAluChecker #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opCode   (opCode),
  .operand  (operand),
  .exec     (exec),
  .intEnSet (intEnSet),
  .intEnClr (intEnClr),
  .acc      (acc),
  .flags    (flags)
);

// File: tb/accAlu_test.sv
module accAlu_test;

  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [3:0]   opCode = '0;
  logic [W-1:0] operand = '0;
  logic         exec = 1'b0;
  logic         intEnSet = 1'b0;
  logic         intEnClr = 1'b0;
  logic [W-1:0] acc;
  logic [6:0]   flags;

  int checks = 0;
  int fails  = 0;

  logic [W-1:0] expAcc = '0;
  logic [6:0]   expFl  = '0;

  always #4 clk = ~clk;

  accAlu #(.WIDTH(W)) uut (
    .clk      (clk),
    .rst      (rst),
    .opCode   (opCode),
    .operand  (operand),
    .exec     (exec),
    .intEnSet (intEnSet),
    .intEnClr (intEnClr),
    .acc      (acc),
    .flags    (flags)
  );

  // reference arithmetic from the requirements
  function automatic logic [W+6:0] model(input int op, input int a, input int b, input logic [6:0] fl);
    int mask = (1 << W) - 1;
    int hm   = (1 << (W / 2)) - 1;
    int bb   = 0;
    int cin  = 0;
    int r    = 0;
    int s;
    int ones = 0;
    bit adder = 1'b1;
    logic [6:0] nf = fl;
    case (op)
      0: begin bb = b; cin = 0; end
      1: begin bb = b; cin = int'(fl[0]); end
      2: begin bb = (~b) & mask; cin = 1; end
      3: begin adder = 1'b0; r = a & b; end
      4: begin adder = 1'b0; r = a | b; end
      5: begin adder = 1'b0; r = (~a) & mask; end
      6: begin adder = 1'b0; r = 0; end
      7: begin bb = 0; cin = 1; end
      8: begin bb = mask; cin = 0; end
      default: return {fl, a[W-1:0]};
    endcase
    if (adder) begin
      s = a + bb + cin;
      r = s & mask;
      if (op != 7 && op != 8) nf[0] = s[W];
      nf[5] = (((a & hm) + (bb & hm) + cin) >> (W / 2)) != 0;
      nf[2] = (a[W-1] == bb[W-1]) && (r[W-1] != a[W-1]);
    end else begin
      nf[0] = 1'b0;
      nf[2] = 1'b0;
      nf[5] = 1'b0;
    end
    for (int i = 0; i < W; i++) ones += (r >> i) & 1;
    nf[1] = (r == 0);
    nf[3] = r[W-1];
    nf[4] = (ones % 2 == 0);
    return {nf, r[W-1:0]};
  endfunction

  function automatic string opTag(input int op);
    if (op <= 2) return "R3";
    if (op <= 6) return "R4";
    if (op <= 8) return "R5";
    return "R2";
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic compareAll(input string mainTag);
    chk(mainTag, "acc", int'(acc), int'(expAcc));
    chk(mainTag, "carry", int'(flags[0]), int'(expFl[0]));
    chk("R6", "zero", int'(flags[1]), int'(expFl[1]));
    chk("R7", "overflow", int'(flags[2]), int'(expFl[2]));
    chk("R8", "sign", int'(flags[3]), int'(expFl[3]));
    chk("R9", "parity", int'(flags[4]), int'(expFl[4]));
    chk("R10", "half carry", int'(flags[5]), int'(expFl[5]));
    chk("R11", "interrupt enable", int'(flags[6]), int'(expFl[6]));
  endtask

  // drive at a falling edge, check at the next falling edge
  task automatic issue(input int op, input int b, input bit ex, input bit s, input bit c);
    logic [W+6:0] m;
    opCode   = 4'(op);
    operand  = W'(b);
    exec     = ex;
    intEnSet = s;
    intEnClr = c;
    if (ex) begin
      m      = model(op, int'(expAcc), b, expFl);
      expAcc = m[W-1:0];
      expFl  = m[W+6:W];
    end
    if (c)      expFl[6] = 1'b0;
    else if (s) expFl[6] = 1'b1;
    @(negedge clk);
    compareAll(ex ? opTag(op) : "R2");
  endtask

  task automatic doReset();
    rst      = 1'b1;
    exec     = 1'b0;
    intEnSet = 1'b0;
    intEnClr = 1'b0;
    @(negedge clk);
    rst    = 1'b0;
    expAcc = '0;
    expFl  = '0;
    chk("R1", "acc after reset", int'(acc), 0);
    chk("R1", "flags after reset", int'(flags), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    @(negedge clk);
    @(negedge clk);
    doReset();

    // full sweep of every code over every operand pair
    for (int a = 0; a < (1 << W); a++) begin
      for (int b = 0; b < (1 << W); b++) begin
        for (int op = 0; op < 16; op++) begin
          issue(6, 0, 1'b1, 1'b0, 1'b0);
          issue(0, a, 1'b1, 1'b0, 1'b0);
          issue(op, b, 1'b1, 1'b0, 1'b0);
        end
        // carry preloaded to one by subtracting zero
        for (int k = 0; k < 3; k++) begin
          issue(6, 0, 1'b1, 1'b0, 1'b0);
          issue(0, a, 1'b1, 1'b0, 1'b0);
          issue(2, 0, 1'b1, 1'b0, 1'b0);
          issue((k == 0) ? 1 : (k == 1 ? 7 : 8), b, 1'b1, 1'b0, 1'b0);
        end
      end
    end

    // R2: strobe low leaves state untouched
    issue(0, 7, 1'b1, 1'b0, 1'b0);
    issue(2, 3, 1'b1, 1'b0, 1'b0);
    for (int op = 0; op < 9; op++) issue(op, 5, 1'b0, 1'b0, 1'b0);

    // R11: set, hold, clear priority, independence from ALU ops
    issue(6, 0, 1'b0, 1'b1, 1'b0);
    issue(6, 0, 1'b0, 1'b0, 1'b0);
    issue(5, 0, 1'b1, 1'b0, 1'b0);
    issue(6, 0, 1'b1, 1'b0, 1'b0);
    issue(6, 0, 1'b0, 1'b1, 1'b1);
    issue(6, 0, 1'b0, 1'b1, 1'b0);
    issue(6, 0, 1'b0, 1'b0, 1'b1);
    issue(6, 0, 1'b1, 1'b1, 1'b0);

    // R1: reset from a busy state
    issue(0, 9, 1'b1, 1'b0, 1'b0);
    issue(2, 1, 1'b1, 1'b1, 1'b0);
    doReset();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule